// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bus Controller

This block sits between a synchronous request port and a byte-wide asynchronous static memory with a 19-bit address bus (524,288 bytes). It turns each accepted read or write request into one correctly timed strobe sequence on the memory's active-low chip enable, output enable and write enable. It steers the data bus by means of a separate driver-enable output and captures read data into a register.

Every timing limit is given in nanoseconds as a parameter and is rounded up to whole clock cycles against the clock-period parameter. A read holds chip enable and output enable low for the longest of the address, chip-enable, output-enable and cycle-time limits. A write holds chip enable and write enable low together for the write-pulse limit. The controller drives write data only inside the write window and for the hold time after it. A recovery interval with all strobes high follows every access, and the address stays put throughout.

The request side follows valid/ready rules. `req_ready` is high only when the controller is idle and `pwr_fail` is low. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_valid` is high and not yet taken, the requester must hold all request fields steady. The response is a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must always be able to accept it. A power failure holds off new requests. It also cuts an access in progress short: the controller goes to recovery and still acknowledges. After a cut-short read, `rsp_rdata` keeps its previous value.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and rsp_valid is 0. After reset, req_ready is 1.
- R2: req_ready is 1 only when the controller is idle and pwr_fail is 0. After a request is taken, req_ready stays 0 until the acknowledge.
- R3: A read holds mem_ce_n and mem_oe_n at 0 and mem_we_n at 1 for exactly RD_CYC cycles. RD_CYC is the largest of the rounded-up address-access, chip-enable-access, output-enable-access and read-cycle times.
- R4: Read data is sampled from mem_dq_in on the last strobe cycle of a read and returned on rsp_rdata. rsp_rdata holds that value until the next completed read.
- R5: A write holds mem_ce_n and mem_we_n at 0 for exactly WP_CYC cycles, with mem_oe_n at 1 throughout. WP_CYC is the larger of the rounded-up write-pulse time and the rounded-up data-setup time plus one. mem_oe_n and mem_we_n are never 0 together.
- R6: mem_dq_oe is 0 on the first write-strobe cycle and 1 on the remaining WP_CYC-1 cycles. It stays 1 for exactly DH_CYC cycles after the strobes rise, where DH_CYC is the rounded-up hold time (at least 1). It is never 1 while mem_oe_n is 0.
- R7: mem_addr is constant from the first strobe cycle to the end of recovery. After the strobes rise, recovery lasts REC_CYC cycles (the rounded-up recovery time, at least 1).
- R8: rsp_valid is a single-cycle pulse. A read is acknowledged RD_CYC+REC_CYC clock edges after the accepting edge, and a write WP_CYC+DH_CYC+REC_CYC edges after it.
- R9: One cycle after pwr_fail is seen high, mem_ce_n is 1 and mem_dq_oe is 0. Any access in progress goes straight to recovery and is still acknowledged. A request offered during pwr_fail is not taken until pwr_fail returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Supply-failure indication, synchronous to clk |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 8 | Last captured read data |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_in | input | 8 | Data from the memory pads |
| mem_dq_out | output | 8 | Data to the memory pads |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume that pwr_fail and all request inputs are synchronous to clk. They also assume that the request fields do not change while a request waits for req_ready. The stimulus changes inputs only on the falling clock edge and holds each request steady until it is taken. The bench's memory model returns data only while chip enable and output enable are both low, and it records a write only when the driver is still on at the rising write strobe. The power-fail stimulus raises pwr_fail in the middle of a write strobe. It also holds pwr_fail high while a request waits, which exercises both the cut-short path and the held-off path.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RD,
    SEQ_WR,
    SEQ_HOLD,
    SEQ_REC
  } seq_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int floor_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R7: phase lengths rely on a strict one-per-cycle countdown
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 4,
  parameter int WP_CYC  = 4,
  parameter int DH_CYC  = 1,
  parameter int REC_CYC = 1,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_zero,
  input  logic [CW-1:0] tmr_cnt,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          req_ready,
  output logic          accept,
  output logic          capture,
  output logic          busy,
  output logic          rsp_valid,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] DH_LD  = CW'(DH_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);

  seq_state_e st, nst;
  logic       done;

  assign req_ready = (st == SEQ_IDLE) && !pwr_fail;
  assign accept    = req_ready && req_valid;
  assign busy      = (st != SEQ_IDLE);

  always_comb begin
    nst      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    done     = 1'b0;
    unique case (st)
      SEQ_IDLE: if (accept) begin
        nst      = req_write ? SEQ_WR : SEQ_RD;
        tmr_load = 1'b1;
        tmr_val  = req_write ? WP_LD : RD_LD;
      end
      SEQ_RD, SEQ_WR, SEQ_HOLD: begin
        if (pwr_fail) begin
          nst      = SEQ_REC;
          tmr_load = 1'b1;
          tmr_val  = REC_LD;
        end else if (tmr_zero) begin
          tmr_load = 1'b1;
          if (st == SEQ_WR) begin
            nst     = SEQ_HOLD;
            tmr_val = DH_LD;
          end else begin
            nst     = SEQ_REC;
            tmr_val = REC_LD;
            capture = (st == SEQ_RD);
          end
        end
      end
      SEQ_REC: if (tmr_zero) begin
        nst  = SEQ_IDLE;
        done = 1'b1;
      end
      default: nst = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      st        <= nst;
      rsp_valid <= done;
    end
  end

  assign ce_n  = !((st == SEQ_RD) || (st == SEQ_WR));
  assign oe_n  = (st != SEQ_RD);
  assign we_n  = (st != SEQ_WR);
  assign dq_oe = ((st == SEQ_WR) && (tmr_cnt != WP_LD)) || (st == SEQ_HOLD);

  // R5: output enable and write enable never active together
  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R6: controller driver never fights the memory's output
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R8: acknowledge lasts one cycle
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: supply failure quiets the bus on the next cycle
  p_pf_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (ce_n && !dq_oe));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 19,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ADDR_ACC_NS = 70,
  parameter int T_CE_ACC_NS   = 70,
  parameter int T_OE_ACC_NS   = 35,
  parameter int T_RD_CYC_NS   = 70,
  parameter int T_WR_PULSE_NS = 70,
  parameter int T_SETUP_NS    = 30,
  parameter int T_HOLD_NS     = 5,
  parameter int T_RECOV_NS    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_dq_in,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);

  localparam int RD_CYC  = floor_one(max2(max2(ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                               ns_to_cyc(T_CE_ACC_NS, CLK_PERIOD_NS)),
                                          max2(ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS),
                                               ns_to_cyc(T_RD_CYC_NS, CLK_PERIOD_NS))));
  localparam int WP_CYC  = max2(ns_to_cyc(T_WR_PULSE_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS) + 1);
  localparam int DH_CYC  = floor_one(ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS));
  localparam int REC_CYC = floor_one(ns_to_cyc(T_RECOV_NS, CLK_PERIOD_NS));
  localparam int CNT_MAX = max2(max2(RD_CYC, WP_CYC), max2(DH_CYC, REC_CYC));
  localparam int CW      = floor_one($clog2(CNT_MAX + 1));

  logic          tmr_load, tmr_zero, accept, capture, busy;
  logic [CW-1:0] tmr_val, tmr_cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .DH_CYC (DH_CYC),
    .REC_CYC(REC_CYC),
    .CW     (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_zero  (tmr_zero),
    .tmr_cnt   (tmr_cnt),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;

  // R7: address frozen for the whole access including recovery
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

  // R2: a taken request closes the port until acknowledge
  p_accept_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4: capture happens only while the memory is driving
  p_capture_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!mem_ce_n && !mem_oe_n && mem_we_n));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

  localparam int PER = 20;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD  = mx(mx(cdiv(70), cdiv(70)), mx(cdiv(35), cdiv(70)));
  localparam int E_WP  = mx(cdiv(70), cdiv(30) + 1);
  localparam int E_DH  = mx(cdiv(5), 1);
  localparam int E_REC = mx(cdiv(5), 1);

  // {is_write, address, data (write data or expected read data)}
  localparam logic [27:0] VEC [10] = '{
    {1'b1, 19'h00000, 8'hA5},
    {1'b1, 19'h7FFFF, 8'h3C},
    {1'b0, 19'h00000, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h00155, 8'hFF},
    {1'b1, 19'h002AA, 8'h00},
    {1'b0, 19'h00155, 8'hFF},
    {1'b0, 19'h002AA, 8'h00},
    {1'b1, 19'h00000, 8'h5A},
    {1'b0, 19'h00000, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_fail = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;

  logic [7:0]  mdl [1024];
  int          n_chk = 0;
  int          n_err = 0;
  bit          finished = 1'b0;
  bit          abort_win = 1'b0;

  always #(PER/2) clk = ~clk;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? mdl[mem_addr[9:0]] : 8'h00;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bus monitor: strobe widths, driver window, address stability, memory model
  bit          prev_rd = 1'b0, prev_wr = 1'b0, hold_on = 1'b0;
  int          rd_run = 0, wr_run = 0, drv_run = 0, hold_run = 0;
  logic [18:0] run_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_oe_n) begin
        if (!prev_rd) begin rd_run = 1; run_addr = mem_addr; end
        else begin
          rd_run++;
          chk(mem_addr == run_addr, "R7 read addr stable", 32'(mem_addr), 32'(run_addr));
        end
        chk(!mem_dq_oe && mem_we_n, "R3 read strobes/driver", 32'(mem_dq_oe), 32'h0);
      end else if (prev_rd && !abort_win)
        chk(rd_run == E_RD, "R3 read strobe width", 32'(rd_run), 32'(E_RD));

      if (!mem_ce_n && !mem_we_n) begin
        if (!prev_wr) begin
          wr_run = 1; drv_run = 0; run_addr = mem_addr;
          chk(!mem_dq_oe, "R6 driver off first cycle", 32'(mem_dq_oe), 32'h0);
        end else begin
          wr_run++;
          chk(mem_addr == run_addr, "R7 write addr stable", 32'(mem_addr), 32'(run_addr));
        end
        if (mem_dq_oe) drv_run++;
        chk(mem_oe_n, "R5 oe high in write", 32'(mem_oe_n), 32'h1);
      end else if (prev_wr && mem_dq_oe) begin
        chk(wr_run == E_WP, "R5 write strobe width", 32'(wr_run), 32'(E_WP));
        chk(drv_run == E_WP - 1, "R6 driver setup cycles", 32'(drv_run), 32'(E_WP - 1));
        chk(mem_addr == run_addr, "R7 addr after strobe", 32'(mem_addr), 32'(run_addr));
        mdl[mem_addr[9:0]] = mem_dq_out;
        hold_on = 1'b1; hold_run = 1;
      end else if (hold_on) begin
        if (mem_dq_oe) hold_run++;
        else begin
          chk(hold_run == E_DH, "R6 driver hold cycles", 32'(hold_run), 32'(E_DH));
          hold_on = 1'b0;
        end
      end
      prev_rd = !mem_ce_n && !mem_oe_n;
      prev_wr = !mem_ce_n && !mem_we_n;
    end
  end

  task automatic run_txn(input logic w, input logic [18:0] a, input logic [7:0] d,
                         output int lat, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low while busy", 32'(req_ready), 32'h0);
    lat = 0;
    while (!rsp_valid) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R8 ack single cycle", 32'(rsp_valid), 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int          lat;
    logic [7:0]  rd;
    for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
        32'({mem_ce_n, mem_oe_n, mem_we_n}), 32'h7);
    chk(!mem_dq_oe && !rsp_valid, "R1 driver/ack low in reset",
        32'({mem_dq_oe, rsp_valid}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", 32'(req_ready), 32'h1);

    // table walk: R3 R4 R5 R8
    for (int i = 0; i < 10; i++) begin
      run_txn(VEC[i][27], VEC[i][26:8], VEC[i][7:0], lat, rd);
      if (VEC[i][27]) begin
        chk(lat == E_WP + E_DH + E_REC, "R8 write latency", 32'(lat), 32'(E_WP + E_DH + E_REC));
      end else begin
        chk(lat == E_RD + E_REC, "R8 read latency", 32'(lat), 32'(E_RD + E_REC));
        chk(rd == VEC[i][7:0], "R4 read data", 32'(rd), 32'(VEC[i][7:0]));
      end
    end

    // R4: read data register unaffected by a following write
    run_txn(1'b1, 19'h00100, 8'h11, lat, rd);
    chk(rsp_rdata == 8'h5A, "R4 rdata held across write", 32'(rsp_rdata), 32'h5A);

    // R9: write cut short by power failure, still acknowledged
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00200; req_wdata = 8'h77;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; abort_win = 1'b1;
    @(negedge clk);
    pwr_fail = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n, "R9 strobes high after pwr_fail",
        32'({mem_ce_n, mem_we_n}), 32'h3);
    chk(!mem_dq_oe, "R9 driver off after pwr_fail", 32'(mem_dq_oe), 32'h0);
    lat = 0;
    while (!rsp_valid && lat < 20) begin @(negedge clk); lat++; end
    chk(rsp_valid, "R9 aborted access acknowledged", 32'(rsp_valid), 32'h1);

    // R9/R2: request offered during pwr_fail is held off
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h002AA;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!req_ready && mem_ce_n, "R9 held off during pwr_fail",
          32'({req_ready, mem_ce_n}), 32'h1);
    end
    pwr_fail = 1'b0; abort_win = 1'b0;
    run_txn(1'b0, 19'h002AA, 8'h00, lat, rd);
    chk(lat == E_RD + E_REC, "R9 held request completes", 32'(lat), 32'(E_RD + E_REC));
    chk(rd == 8'h00, "R4 read after pwr_fail", 32'(rd), 32'h00);
    run_txn(1'b0, 19'h00100, 8'h00, lat, rd);
    chk(rd == 8'h11, "R4 read of later write", 32'(rd), 32'h11);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule